// File: doc/BRIEF.md
# Programmable Phase Calibration Delay

This block lines up a stream of voltage samples with a stream of current samples so that a small phase error from an external transducer can be cancelled before the power calculation. Each accepted sample pair is written into a circular buffer. The current sample always leaves after a fixed base delay. The voltage sample leaves after the same base delay plus a signed offset set by a calibration register. The voltage channel can therefore be moved earlier or later than the current channel by a whole number of sample periods.

The calibration register is eight bits wide and two's complement. Its zero point is at 0x40, so the voltage shift in samples is the register value minus 64. The legal values run from -126 (0x82) to +104 (0x68). The voltage delay is therefore base + value - 64: with the default base of 190 it spans 0 to 230 samples, and the current delay stays at 190. A write outside the legal range is clamped to the nearest limit. Until enough samples have come in since reset to fill a channel's delay, that channel outputs zero.

Top module: `phase_align`

## Requirements
- R1: After reset, out_vld, v_out and i_out are zero and the calibration register holds 0x40. This value gives a voltage delay equal to the current delay.
- R2: out_vld is high in the cycle after each cycle with in_vld high, and low otherwise. v_out and i_out hold their values while out_vld is low.
- R3: Sample n of the current channel (counted from 0 after reset) appears on i_out with the n+BASE-th valid input, where BASE is 190 by default.
- R4: Sample n of the voltage channel appears on v_out with the n+D-th valid input, where D = BASE + c - 64 and c is the signed register value. With c = 0x40 the two outputs of each pair come from the same input sample.
- R5: Writing 0x3C sets the shift to -4. The voltage output then comes from an input four samples later than the current output (D = 186).
- R6: The end values of the legal range give D = 0 for 0x82 (v_out shows the sample accepted in the same cycle) and D = 230 for 0x68.
- R7: A written value below -126 (0x80, 0x81) is stored as -126. A written value above +104 (0x69 to 0x7F) is stored as +104. The stored value is seen as the voltage delay it selects.
- R8: While fewer than D valid samples (or BASE samples for current) have been accepted since reset, the matching output is zero.
- R9: The delays count valid samples only. Idle cycles between samples do not move either channel.
- R10: A register write takes effect on the next accepted sample. The voltage output is then taken from the buffered history at the new delay, with no refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Calibration register write enable |
| cfg_wdata | input | 8 | Calibration value, signed, zero shift at 0x40 |
| in_vld | input | 1 | Input sample pair valid |
| v_in | input | SW | Voltage sample |
| i_in | input | SW | Current sample |
| out_vld | output | 1 | Output pair valid |
| v_out | output | SW | Delayed voltage sample |
| i_out | output | SW | Delayed current sample |

## Verification
The bench builds the block with its default parameters: 24-bit samples, a 256-entry buffer and a base delay of 190. The full calibration span, 0 to 230 samples of voltage delay, is then reached within a few hundred samples. These values cover the zero-delay bypass at one end, the deepest tap close to the buffer wrap at the other, and several wraps of the write pointer. Clamping is checked by writing out-of-range codes and observing the voltage delay that results. A second reset partway through the run checks the refill-with-zeros behaviour again.

// File: rtl/phase_align.sv
module phase_align #(
  parameter int SW       = 24,
  parameter int DEPTH    = 256,
  parameter int BASE     = 190,
  parameter int CENTER   = 64,
  parameter int CAL_MIN  = -126,
  parameter int CAL_MAX  = 104,
  parameter logic [7:0] CAL_RST = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          in_vld,
  input  logic [SW-1:0] v_in,
  input  logic [SW-1:0] i_in,
  output logic          out_vld,
  output logic [SW-1:0] v_out,
  output logic [SW-1:0] i_out
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] I_DLY = AW'(BASE);

  logic signed [7:0] cal_q, wd_clamped;
  logic [AW-1:0] wp, v_dly;
  logic [AW:0]   fill;
  logic [SW-1:0] vmem [DEPTH];
  logic [SW-1:0] imem [DEPTH];
  logic [SW-1:0] v_rd, i_rd;
  logic          v_ok, i_ok;

  always_comb begin
    if (int'($signed(cfg_wdata)) < CAL_MIN)      wd_clamped = 8'(CAL_MIN);
    else if (int'($signed(cfg_wdata)) > CAL_MAX) wd_clamped = 8'(CAL_MAX);
    else                                          wd_clamped = $signed(cfg_wdata);
  end

  assign v_dly = AW'(BASE + int'(cal_q) - CENTER);
  assign v_rd  = (v_dly == '0) ? v_in : vmem[wp - v_dly];
  assign i_rd  = (I_DLY == '0) ? i_in : imem[wp - I_DLY];
  assign v_ok  = fill >= {1'b0, v_dly};
  assign i_ok  = fill >= {1'b0, I_DLY};

  always_ff @(posedge clk) begin
    if (in_vld) begin
      vmem[wp] <= v_in;
      imem[wp] <= i_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q   <= CAL_RST;
      wp      <= '0;
      fill    <= '0;
      out_vld <= 1'b0;
      v_out   <= '0;
      i_out   <= '0;
    end else begin
      if (cfg_we) cal_q <= wd_clamped;
      out_vld <= in_vld;
      if (in_vld) begin
        wp    <= wp + 1'b1;
        if (!fill[AW]) fill <= fill + 1'b1;
        v_out <= v_ok ? v_rd : '0;
        i_out <= i_ok ? i_rd : '0;
      end
    end
  end
endmodule

// File: rtl/phase_align_chk.sv
module phase_align_chk #(
  parameter int SW      = 24,
  parameter int BASE    = 190,
  parameter int CAL_MIN = -126,
  parameter int CAL_MAX = 104
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          out_vld,
  input logic [SW-1:0] v_out,
  input logic [SW-1:0] i_out,
  input logic [7:0]    cal
);
  logic [15:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (in_vld && seen < 16'(BASE)) seen <= seen + 1'b1;
  end

  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(v_out) && $stable(i_out)));
  assert_cal_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'($signed(cal)) >= CAL_MIN && int'($signed(cal)) <= CAL_MAX));
  assert_fill_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && seen < 16'(BASE)) |=> (i_out == '0));
endmodule

bind phase_align phase_align_chk #(
  .SW(SW), .BASE(BASE), .CAL_MIN(CAL_MIN), .CAL_MAX(CAL_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld),
  .v_out(v_out), .i_out(i_out), .cal(cal_q)
);

// File: tb/sim_phase_align.sv
module sim_phase_align;
  localparam int SW = 24;
  localparam int BASE = 190;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, in_vld = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [SW-1:0] v_in = '0, i_in = '0;
  logic out_vld;
  logic [SW-1:0] v_out, i_out;

  phase_align u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_vld(in_vld), .v_in(v_in), .i_in(i_in),
    .out_vld(out_vld), .v_out(v_out), .i_out(i_out)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int k = 0;
  int mcal = 64;
  logic [SW-1:0] hv [4096];
  logic [SW-1:0] hi [4096];
  logic [SW-1:0] qv [$];
  logic [SW-1:0] qi [$];
  string qt [$];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag);
    int dv;
    dv = BASE + mcal - 64;
    hv[k] = SW'(k * 7919 + 13);
    hi[k] = SW'(k * 104729 + 5) ^ 24'h5A0000;
    v_in = hv[k];
    i_in = hi[k];
    in_vld = 1'b1;
    qv.push_back((k >= dv) ? hv[k - dv] : '0);
    qi.push_back((k >= BASE) ? hi[k - BASE] : '0);
    qt.push_back(tag);
    k++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_vld = 1'b0;
    for (int j = 0; j < n; j++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    int s;
    in_vld = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    s = int'($signed(d));
    if (s < -126) s = -126;
    if (s > 104) s = 104;
    mcal = s;
  endtask

  task automatic stream(input int n, input string tag);
    for (int j = 0; j < n; j++) send(tag);
    idle(2);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (qv.size() == 0) begin
        chk(1'b0, "R2 unexpected out_vld", 1, 0);
      end else begin
        logic [SW-1:0] ev, ei;
        string t;
        ev = qv.pop_front();
        ei = qi.pop_front();
        t = qt.pop_front();
        chk(v_out == ev, {t, " v_out"}, v_out, ev);
        chk(i_out == ei, {t, " i_out"}, i_out, ei);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    k = 0;
    mcal = 64;
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 out_vld", out_vld, 0);
    chk(v_out == '0, "R1 v_out", v_out, 0);
    chk(i_out == '0, "R1 i_out", i_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    stream(260, "R3 R4 R8 default");
    wr(8'h3C);
    stream(20, "R5 advance by 4");
    wr(8'h82);
    stream(10, "R6 min code");
    wr(8'h68);
    stream(240, "R6 max code");
    for (int j = 0; j < 30; j++) begin
      send("R9 gaps");
      idle((j % 3) + 1);
    end
    idle(2);
    wr(8'h80);
    stream(10, "R7 clamp low 0x80");
    wr(8'h81);
    stream(6, "R7 clamp low 0x81");
    wr(8'h7F);
    stream(10, "R7 clamp high 0x7F");
    wr(8'h69);
    stream(6, "R7 clamp high 0x69");
    wr(8'h40);
    stream(8, "R10 back to centre");
    send("R10 pre-change");
    wr(8'h41);
    stream(8, "R10 after change");
    idle(3);
    chk(qv.size() == 0, "R2 queue drained", qv.size(), 0);
    do_reset();
    stream(200, "R1 R8 refill");
    idle(3);
    chk(qv.size() == 0, "R2 queue drained after refill", qv.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule